// File: doc/BRIEF.md
# Coherence Probe Event Classifier

This block sits at the probe input of a cache controller. Each forwarded coherence request is decoded into one internal event code, and in the same step the block assembles the header of the data reply that goes back. The header is made of the reply kind, the destination set of caches, the acknowledgement count and the dirty flag. The event depends on:

- the request kind,
- how many caches the system has (a run-time input),
- whether the probed line is present,
- whether the line has been touched by an atomic store while migration of such lines is disabled.

A small per-line status table records the valid, dirty and atomic-touched bits that the classification needs. The table is updated by a line-update port (fill, store, atomic store, evict). Results leave through a registered output stage with a valid/ready handshake, one result per accepted probe, in order.

Top module: `probe_classifier`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and every line reads as absent, so any probe gets reply kind 0 (none).
- R2: A shared-read probe (kind 1) when `cfg_num_caches` is 0 or 1 gives event 3 (non-coherent DMA read), and on a present line reply kind 1 (plain data).
- R3: With more than one cache, a shared-read probe on a present line whose atomic bit is set, while `cfg_no_migrate` is 1, gives event 2 (shared read, no migration) with reply kind 2 (shared data).
- R4: Every other shared-read probe gives event 1 (shared read), including misses, non-atomic lines and `cfg_no_migrate` at 0. On a present line the reply kind is 2.
- R5: Kinds 0 (exclusive read), 2 (merged shared read), 3 (invalidate), 4 (writeback ack) and 5 (writeback nack) give events 0, 4, 5, 6 and 7. Kinds 6 and 7 give error event 15. Invalidate, the writeback kinds and the error event never carry a reply (kind 0).
- R6: A reply from a merged read or a directed probe carries an ack count equal to `cfg_num_caches`. A reply from any other probe carries 1. No reply means a count of 0.
- R7: A merged-read reply is addressed to `in_merged`. Other replies go to the single cache whose bit index is `in_src`. No reply means destination 0.
- R8: An exclusive-read probe on a present line gives reply kind 3 (exclusive data). Any reply copies the line's dirty bit into `out_dirty`, which is 0 when there is no reply.
- R9: The `upd_op` codes are: 0 (fill) sets present, clean, not atomic; 1 (store) sets dirty; 2 (atomic store) sets dirty and atomic; 3 (evict) clears the line. Stores and atomic stores to an absent line have no effect.
- R10: When an update and an accepted probe name the same line in the same cycle, the probe is classified from the line status as it was before that update.
- R11: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, all result outputs hold. Results come out in acceptance order, one per accepted probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Probe present |
| in_ready | output | 1 | Probe accepted this cycle when high with in_valid |
| in_kind | input | 3 | Request kind code |
| in_src | input | SRC_W (3) | Requesting cache index |
| in_idx | input | IDX_W (4) | Line index of the probe |
| in_directed | input | 1 | Probe was sent to this cache alone |
| in_merged | input | MAX_CACHES (8) | Merged requestor set |
| cfg_no_migrate | input | 1 | Keep atomically touched lines from migrating |
| cfg_num_caches | input | CNT_W (4) | Number of caches in the system |
| upd_en | input | 1 | Line update strobe |
| upd_idx | input | IDX_W (4) | Line index to update |
| upd_op | input | 2 | Update operation code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken this cycle when high with out_valid |
| out_event | output | 4 | Event code |
| out_rsp | output | 2 | Reply kind |
| out_dest | output | MAX_CACHES (8) | Reply destination set |
| out_acks | output | CNT_W (4) | Reply ack count |
| out_dirty | output | 1 | Dirty flag carried with the reply |

## Verification
A line update and a probe of the same line can land in the same clock cycle. That is where the ordering of status reads against status writes becomes visible. The bench drives a fill together with an exclusive-read probe of an absent line in one cycle, and a store together with a probe of a clean line in one cycle. It expects the first result to show no reply and the second a clean reply. The follow-up probe after each pair must then show the updated state.

// File: rtl/probe_cls_pkg.sv
package probe_cls_pkg;

  typedef enum logic [2:0] {
    KIND_GETX   = 3'd0,
    KIND_GETS   = 3'd1,
    KIND_MGETS  = 3'd2,
    KIND_INV    = 3'd3,
    KIND_WBACK  = 3'd4,
    KIND_WBNACK = 3'd5
  } probe_kind_e;

  typedef enum logic [3:0] {
    EV_OTHER_X       = 4'd0,
    EV_OTHER_S       = 4'd1,
    EV_OTHER_S_NOMIG = 4'd2,
    EV_DMA_S         = 4'd3,
    EV_MERGED_S      = 4'd4,
    EV_INVAL         = 4'd5,
    EV_WB_ACK        = 4'd6,
    EV_WB_NACK       = 4'd7,
    EV_BAD           = 4'd15
  } probe_event_e;

  typedef enum logic [1:0] {
    RSP_NONE   = 2'd0,
    RSP_DATA   = 2'd1,
    RSP_SHARED = 2'd2,
    RSP_EXCL   = 2'd3
  } rsp_kind_e;

  typedef enum logic [1:0] {
    OP_FILL   = 2'd0,
    OP_STORE  = 2'd1,
    OP_ATOMIC = 2'd2,
    OP_EVICT  = 2'd3
  } line_op_e;

endpackage

// File: rtl/probe_line_status.sv
module probe_line_status import probe_cls_pkg::*; #(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [1:0]       upd_op,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic             rd_atomic
);

  logic [LINES-1:0] vld_q, drt_q, atm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      drt_q <= '0;
      atm_q <= '0;
    end else if (upd_en) begin
      case (line_op_e'(upd_op))
        OP_FILL: begin
          vld_q[upd_idx] <= 1'b1;
          drt_q[upd_idx] <= 1'b0;
          atm_q[upd_idx] <= 1'b0;
        end
        OP_STORE: begin
          if (vld_q[upd_idx]) drt_q[upd_idx] <= 1'b1;
        end
        OP_ATOMIC: begin
          if (vld_q[upd_idx]) begin
            drt_q[upd_idx] <= 1'b1;
            atm_q[upd_idx] <= 1'b1;
          end
        end
        default: begin
          vld_q[upd_idx] <= 1'b0;
          drt_q[upd_idx] <= 1'b0;
          atm_q[upd_idx] <= 1'b0;
        end
      endcase
    end
  end

  // Read returns the pre-update contents of this cycle.
  assign rd_valid  = vld_q[rd_idx];
  assign rd_dirty  = drt_q[rd_idx];
  assign rd_atomic = atm_q[rd_idx];

  for (genvar g = 0; g < LINES; g++) begin : g_chk
    AST_ATOMIC_DIRTY: assert property (@(posedge clk) disable iff (rst)
      atm_q[g] |-> (drt_q[g] && vld_q[g])); // R9
    AST_STORE_ABSENT: assert property (@(posedge clk) disable iff (rst)
      (upd_en && upd_idx == IDX_W'(g) && upd_op != 2'd0 && !vld_q[g]) |=> !drt_q[g] && !atm_q[g]); // R9
  end

endmodule

// File: rtl/probe_event_decode.sv
module probe_event_decode import probe_cls_pkg::*; #(
  parameter int CNT_W = 4
) (
  input  logic [2:0]       kind,
  input  logic [CNT_W-1:0] num_caches,
  input  logic             hit,
  input  logic             atomic,
  input  logic             no_migrate,
  output probe_event_e     event_o
);

  always_comb begin
    case (kind)
      KIND_GETX:   event_o = EV_OTHER_X;
      KIND_GETS: begin
        if (num_caches <= CNT_W'(1))
          event_o = EV_DMA_S;
        else if (hit && atomic && no_migrate)
          event_o = EV_OTHER_S_NOMIG;
        else
          event_o = EV_OTHER_S;
      end
      KIND_MGETS:  event_o = EV_MERGED_S;
      KIND_INV:    event_o = EV_INVAL;
      KIND_WBACK:  event_o = EV_WB_ACK;
      KIND_WBNACK: event_o = EV_WB_NACK;
      default:     event_o = EV_BAD;
    endcase
  end

endmodule

// File: rtl/probe_resp_build.sv
module probe_resp_build import probe_cls_pkg::*; #(
  parameter int MAX_CACHES = 8,
  localparam int SRC_W = $clog2(MAX_CACHES),
  localparam int CNT_W = $clog2(MAX_CACHES + 1)
) (
  input  probe_event_e          event_i,
  input  logic                  hit,
  input  logic                  line_dirty,
  input  logic [SRC_W-1:0]      src,
  input  logic [MAX_CACHES-1:0] merged,
  input  logic                  directed,
  input  logic [CNT_W-1:0]      num_caches,
  output rsp_kind_e             rsp_o,
  output logic [MAX_CACHES-1:0] dest_o,
  output logic [CNT_W-1:0]      acks_o,
  output logic                  dirty_o
);

  rsp_kind_e kind_raw;

  always_comb begin
    case (event_i)
      EV_OTHER_X:                              kind_raw = RSP_EXCL;
      EV_OTHER_S, EV_OTHER_S_NOMIG, EV_MERGED_S: kind_raw = RSP_SHARED;
      EV_DMA_S:                                kind_raw = RSP_DATA;
      default:                                 kind_raw = RSP_NONE;
    endcase
  end

  always_comb begin
    rsp_o   = hit ? kind_raw : RSP_NONE;
    dest_o  = '0;
    acks_o  = '0;
    dirty_o = 1'b0;
    if (rsp_o != RSP_NONE) begin
      dirty_o = line_dirty;
      if (event_i == EV_MERGED_S) begin
        dest_o = merged;
        acks_o = num_caches;
      end else begin
        dest_o = MAX_CACHES'(1) << src;
        acks_o = directed ? num_caches : CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/probe_classifier.sv
module probe_classifier import probe_cls_pkg::*; #(
  parameter int MAX_CACHES = 8,
  parameter int LINES = 16,
  localparam int SRC_W = $clog2(MAX_CACHES),
  localparam int CNT_W = $clog2(MAX_CACHES + 1),
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2:0]            in_kind,
  input  logic [SRC_W-1:0]      in_src,
  input  logic [IDX_W-1:0]      in_idx,
  input  logic                  in_directed,
  input  logic [MAX_CACHES-1:0] in_merged,
  input  logic                  cfg_no_migrate,
  input  logic [CNT_W-1:0]      cfg_num_caches,
  input  logic                  upd_en,
  input  logic [IDX_W-1:0]      upd_idx,
  input  logic [1:0]            upd_op,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [3:0]            out_event,
  output logic [1:0]            out_rsp,
  output logic [MAX_CACHES-1:0] out_dest,
  output logic [CNT_W-1:0]      out_acks,
  output logic                  out_dirty
);

  logic                  ln_valid, ln_dirty, ln_atomic;
  probe_event_e          ev_c;
  rsp_kind_e             rsp_c;
  logic [MAX_CACHES-1:0] dest_c;
  logic [CNT_W-1:0]      acks_c;
  logic                  dirty_c;

  probe_line_status #(.LINES(LINES)) u_status (
    .clk       (clk),
    .rst       (rst),
    .upd_en    (upd_en),
    .upd_idx   (upd_idx),
    .upd_op    (upd_op),
    .rd_idx    (in_idx),
    .rd_valid  (ln_valid),
    .rd_dirty  (ln_dirty),
    .rd_atomic (ln_atomic)
  );

  probe_event_decode #(.CNT_W(CNT_W)) u_decode (
    .kind       (in_kind),
    .num_caches (cfg_num_caches),
    .hit        (ln_valid),
    .atomic     (ln_atomic),
    .no_migrate (cfg_no_migrate),
    .event_o    (ev_c)
  );

  probe_resp_build #(.MAX_CACHES(MAX_CACHES)) u_resp (
    .event_i    (ev_c),
    .hit        (ln_valid),
    .line_dirty (ln_dirty),
    .src        (in_src),
    .merged     (in_merged),
    .directed   (in_directed),
    .num_caches (cfg_num_caches),
    .rsp_o      (rsp_c),
    .dest_o     (dest_c),
    .acks_o     (acks_c),
    .dirty_o    (dirty_c)
  );

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_event <= '0;
      out_rsp   <= '0;
      out_dest  <= '0;
      out_acks  <= '0;
      out_dirty <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_event <= ev_c;
        out_rsp   <= rsp_c;
        out_dest  <= dest_c;
        out_acks  <= acks_c;
        out_dirty <= dirty_c;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_event) && $stable(out_rsp)
      && $stable(out_dest) && $stable(out_acks) && $stable(out_dirty)); // R11
  AST_NONE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_rsp == 2'd0) |-> (out_acks == '0 && out_dest == '0 && !out_dirty)); // R6
  AST_SINGLE_DEST: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_rsp != 2'd0 && out_event != 4'd4) |-> $countones(out_dest) == 1); // R7
  AST_NOMIG_SHARED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_event == 4'd2) |-> out_rsp == 2'd2); // R3
  AST_NO_REPLY_KINDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_event >= 4'd5) |-> out_rsp == 2'd0); // R5

endmodule

// File: tb/sim_probe_classifier.sv
module sim_probe_classifier;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_ready;
  logic [2:0] in_kind = '0;
  logic [2:0] in_src = '0;
  logic [3:0] in_idx = '0;
  logic       in_directed = 1'b0;
  logic [7:0] in_merged = '0;
  logic       cfg_no_migrate = 1'b0;
  logic [3:0] cfg_num_caches = 4'd4;
  logic       upd_en = 1'b0;
  logic [3:0] upd_idx = '0;
  logic [1:0] upd_op = '0;
  logic       out_valid, out_ready = 1'b1;
  logic [3:0] out_event;
  logic [1:0] out_rsp;
  logic [7:0] out_dest;
  logic [3:0] out_acks;
  logic       out_dirty;

  always #4 clk = ~clk;

  probe_classifier u0 (.*);

  typedef struct packed {
    logic [3:0] ev;
    logic [1:0] rsp;
    logic [7:0] dest;
    logic [3:0] acks;
    logic       dirty;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_tests = 0, n_fail = 0;
  bit    hold_ready = 1'b1;
  bit    done = 1'b0;
  bit    mv[16], md[16], ma[16];
  logic [7:0] lf = 8'hA5;

  function automatic exp_t model(input logic [2:0] k, input logic [2:0] s, input logic [3:0] ix,
                                 input logic dir, input logic [7:0] mg, input logic nm,
                                 input logic [3:0] num);
    exp_t e;
    logic [1:0] r;
    e = '0;
    r = 2'd0;
    case (k)
      3'd0: begin e.ev = 4'd0; r = 2'd3; end
      3'd1: begin
        if (num <= 4'd1) begin e.ev = 4'd3; r = 2'd1; end
        else if (mv[ix] && ma[ix] && nm) begin e.ev = 4'd2; r = 2'd2; end
        else begin e.ev = 4'd1; r = 2'd2; end
      end
      3'd2: begin e.ev = 4'd4; r = 2'd2; end
      3'd3: e.ev = 4'd5;
      3'd4: e.ev = 4'd6;
      3'd5: e.ev = 4'd7;
      default: e.ev = 4'd15;
    endcase
    if (!mv[ix]) r = 2'd0;
    e.rsp = r;
    if (r != 2'd0) begin
      e.dirty = md[ix];
      if (k == 3'd2) begin e.dest = mg; e.acks = num; end
      else begin e.dest = 8'd1 << s; e.acks = dir ? num : 4'd1; end
    end
    return e;
  endfunction

  function automatic void apply_upd(input logic [3:0] ix, input logic [1:0] op);
    case (op)
      2'd0: begin mv[ix] = 1; md[ix] = 0; ma[ix] = 0; end
      2'd1: if (mv[ix]) md[ix] = 1;
      2'd2: if (mv[ix]) begin md[ix] = 1; ma[ix] = 1; end
      default: begin mv[ix] = 0; md[ix] = 0; ma[ix] = 0; end
    endcase
  endfunction

  task automatic probe(input logic [2:0] k, input logic [2:0] s, input logic [3:0] ix,
                       input logic dir, input logic [7:0] mg, input logic nm,
                       input logic [3:0] num, input string tag);
    exp_q.push_back(model(k, s, ix, dir, mg, nm, num));
    tag_q.push_back(tag);
    @(negedge clk);
    in_kind = k; in_src = s; in_idx = ix; in_directed = dir;
    in_merged = mg; cfg_no_migrate = nm; cfg_num_caches = num;
    in_valid = 1'b1;
    forever begin
      #3;
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic update(input logic [3:0] ix, input logic [1:0] op);
    apply_upd(ix, op);
    @(negedge clk);
    upd_en = 1'b1; upd_idx = ix; upd_op = op;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  // R10: update and probe of the same line in one cycle (output stage kept free).
  task automatic update_and_probe(input logic [3:0] ix, input logic [1:0] op,
                                  input logic [2:0] k, input string tag);
    exp_q.push_back(model(k, 3'd1, ix, 1'b0, 8'h00, 1'b0, 4'd4));
    tag_q.push_back(tag);
    apply_upd(ix, op);
    @(negedge clk);
    upd_en = 1'b1; upd_idx = ix; upd_op = op;
    in_kind = k; in_src = 3'd1; in_idx = ix; in_directed = 1'b0;
    in_merged = 8'h00; cfg_no_migrate = 1'b0; cfg_num_caches = 4'd4;
    in_valid = 1'b1;
    @(posedge clk);
    #1 begin in_valid = 1'b0; upd_en = 1'b0; end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Back-pressure source
  initial begin
    forever begin
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready = hold_ready ? 1'b1 : lf[0];
    end
  end

  // Monitor: compares each transferred result against the scoreboard (R11 ordering)
  initial begin
    exp_t e, got;
    string t;
    forever begin
      @(posedge clk);
      #6;
      if (!rst && out_valid && out_ready) begin
        got = '{out_event, out_rsp, out_dest, out_acks, out_dirty};
        n_tests++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R11 unexpected result got=%h expected=none", got);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (got !== e) begin
            n_fail++;
            $display("FAIL %s got ev=%0d rsp=%0d dest=%h acks=%0d dirty=%0d expected ev=%0d rsp=%0d dest=%h acks=%0d dirty=%0d",
                     t, got.ev, got.rsp, got.dest, got.acks, got.dirty,
                     e.ev, e.rsp, e.dest, e.acks, e.dirty);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired got=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mv[i] = 0; md[i] = 0; ma[i] = 0; end
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #2;
    n_tests++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset got valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
    end

    probe(3'd1, 3'd2, 4'd3, 1'b0, 8'h00, 1'b0, 4'd4, "R1 miss after reset");
    update(4'd3, 2'd0);
    update(4'd3, 2'd1);
    probe(3'd0, 3'd2, 4'd3, 1'b0, 8'h00, 1'b0, 4'd4, "R8 exclusive dirty broadcast");
    probe(3'd0, 3'd6, 4'd3, 1'b1, 8'h00, 1'b0, 4'd4, "R6 directed ack count");
    update(4'd3, 2'd2);
    probe(3'd1, 3'd0, 4'd3, 1'b0, 8'h00, 1'b1, 4'd4, "R3 no-migration read");
    probe(3'd1, 3'd0, 4'd3, 1'b0, 8'h00, 1'b0, 4'd4, "R4 policy off");
    probe(3'd1, 3'd5, 4'd3, 1'b0, 8'h00, 1'b1, 4'd1, "R2 single cache DMA");
    probe(3'd1, 3'd5, 4'd3, 1'b1, 8'h00, 1'b1, 4'd0, "R2 zero caches DMA");
    update(4'd5, 2'd0);
    probe(3'd1, 3'd4, 4'd5, 1'b0, 8'h00, 1'b1, 4'd4, "R4 non-atomic line");
    probe(3'd2, 3'd4, 4'd5, 1'b0, 8'b0000_1011, 1'b0, 4'd4, "R7 merged set");
    probe(3'd2, 3'd4, 4'd5, 1'b0, 8'b1110_0001, 1'b0, 4'd6, "R6 merged ack count");
    probe(3'd3, 3'd1, 4'd5, 1'b0, 8'h00, 1'b0, 4'd4, "R5 invalidate");
    probe(3'd4, 3'd1, 4'd5, 1'b0, 8'h00, 1'b0, 4'd4, "R5 writeback ack");
    probe(3'd5, 3'd1, 4'd5, 1'b0, 8'h00, 1'b0, 4'd4, "R5 writeback nack");
    probe(3'd6, 3'd1, 4'd5, 1'b0, 8'h00, 1'b0, 4'd4, "R5 illegal kind 6");
    probe(3'd7, 3'd1, 4'd5, 1'b1, 8'h00, 1'b0, 4'd4, "R5 illegal kind 7");
    update(4'd9, 2'd1);
    update(4'd9, 2'd2);
    probe(3'd0, 3'd3, 4'd9, 1'b0, 8'h00, 1'b0, 4'd4, "R9 store to absent line");
    update(4'd3, 2'd0);
    probe(3'd1, 3'd3, 4'd3, 1'b0, 8'h00, 1'b1, 4'd4, "R9 fill clears atomic");
    update(4'd3, 2'd3);
    probe(3'd0, 3'd3, 4'd3, 1'b0, 8'h00, 1'b0, 4'd4, "R9 evict");

    update_and_probe(4'd7, 2'd0, 3'd0, "R10 fill same cycle sees absent");
    probe(3'd0, 3'd1, 4'd7, 1'b0, 8'h00, 1'b0, 4'd4, "R10 after fill");
    update_and_probe(4'd7, 2'd1, 3'd0, "R10 store same cycle sees clean");
    probe(3'd0, 3'd1, 4'd7, 1'b0, 8'h00, 1'b0, 4'd4, "R10 after store");

    hold_ready = 1'b0;
    for (int k = 0; k < 24; k++) begin
      probe(3'(k % 8), 3'(k * 3), (k % 3 == 0) ? 4'd3 : ((k % 3 == 1) ? 4'd5 : 4'd7),
            1'(k), 8'(k * 37), 1'(k >> 1), 4'(1 + k % 7), "R11 stalled burst");
    end
    hold_ready = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    summary();
  end

endmodule